// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block is the fetch front end of a pipelined core. It issues instruction-memory reads ahead of demand and keeps a small queue of fetched words topped up. Each queued word is stored with its own address. The decode stage pops entries from the queue head one at a time. The memory side is a pipelined read port. Each request carries a tag, the port returns one response per request in request order, and each response comes back with the tag of its request.

As each response arrives, the block classifies the word it carries. An unconditional jump is resolved inside the block: the block computes the target and moves fetch there, so the jump is followed in the queue by its target, with no wrong-path entry between them. A conditional branch follows the path picked by a prediction input. Once a conditional branch is accepted, every entry queued after it is marked as speculative.

When execute finds a misprediction, it asserts a redirect with a new address. The redirect empties the queue and restarts fetch at that address. Responses still in flight from before the redirect are recognised by their stale tag and discarded.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is high, `imem_req` and `q_valid` are 0. After reset, the first entry delivered is at `RESET_ADDR` (0 by default).
- R2: Entries leave the queue in program order. Each entry carries the fetched word and its word address. For a word that is not a branch, the next fetch address is the current address plus one.
- R3: The block issues a request only while the queued entries plus the outstanding requests number fewer than `DEPTH` (2 by default). The queue never overflows, and with no pops it stops requesting once it is full.
- R4: A word whose bits [31:30] are 2'b10 is an unconditional jump. The jump itself is queued. The next queued entry is at the jump address plus the sign-extended bits [11:0], and no sequential word comes between the two.
- R5: A word whose bits [31:30] are 2'b11 is a conditional branch. `pred_taken` is sampled in the cycle its response is accepted. If it is 1, the next entry is at the target (same offset rule as R4). If it is 0, the next entry is at the branch address plus one.
- R6: `q_spec` is 0 on every entry until a conditional branch has been accepted. It is 1 on every entry queued after that branch, until the next redirect clears it.
- R7: On `redirect`, the next request goes to `redirect_addr` with a new tag. A response whose tag differs from the current tag is dropped. The first entry after a redirect is at `redirect_addr`.
- R8: A redirect takes priority over a push and a pop in the same cycle. `q_valid` is 0 in the cycle after a redirect.
- R9: While the head entry is valid and not popped, it stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req | output | 1 | Memory read request |
| imem_addr | output | ADDR_W | Word address of the request |
| imem_tag | output | EPOCH_W | Fetch epoch tag of the request |
| imem_rvalid | input | 1 | Response valid |
| imem_rdata | input | INSTR_W | Returned instruction word |
| imem_rtag | input | EPOCH_W | Tag echoed with the response |
| pred_taken | input | 1 | Predicted direction for a conditional branch |
| redirect | input | 1 | Flush request from execute |
| redirect_addr | input | ADDR_W | Restart address for the flush |
| q_valid | output | 1 | Queue head holds an entry |
| q_instr | output | INSTR_W | Instruction word at the head |
| q_addr | output | ADDR_W | Address of the head entry |
| q_spec | output | 1 | Head entry was fetched past a predicted branch |
| q_pop | input | 1 | Consume the head entry |

## Verification
A corrupted fetch or response address shows up at `q_addr` on the first entry that leaves the queue after the fault. That entry either repeats an address, skips one, or lands off the jump or branch target. A stale or mismatched epoch shows up right after a redirect, either as an old-path entry ahead of `redirect_addr` or as a missing entry. A wrong credit count shows up as requests that continue while the queue sits full, or as a queue that never fills. A stuck speculative flag shows up as a wrong `q_spec` on the first entry after a conditional branch or after a redirect.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    parameter int ADDR_W  = 16;
    parameter int INSTR_W = 32;
    parameter int OFF_W   = 12;

    typedef enum logic [1:0] {
        CLS_PLAIN = 2'b00,
        CLS_JUMP  = 2'b01,
        CLS_COND  = 2'b10
    } cls_e;

    typedef struct packed {
        logic [INSTR_W-1:0] instr;
        logic [ADDR_W-1:0]  addr;
        logic               spec;
    } entry_t;

    // The two top bits select the word class.
    function automatic cls_e classify(input logic [INSTR_W-1:0] w);
        case (w[INSTR_W-1 -: 2])
            2'b10:   return CLS_JUMP;
            2'b11:   return CLS_COND;
            default: return CLS_PLAIN;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] branch_target(
        input logic [ADDR_W-1:0]  pc,
        input logic [INSTR_W-1:0] w
    );
        logic [ADDR_W+OFF_W-1:0] wide;
        wide = {{ADDR_W{w[OFF_W-1]}}, w[OFF_W-1:0]};
        return pc + wide[ADDR_W-1:0];
    endfunction

    function automatic logic [ADDR_W-1:0] next_seq(input logic [ADDR_W-1:0] pc);
        return pc + ADDR_W'(1);
    endfunction

endpackage

// File: rtl/pfq_decode.sv
module pfq_decode
    import pfq_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    input  logic [ADDR_W-1:0]  pc,
    output cls_e               cls,
    output logic [ADDR_W-1:0]  target
);
    always_comb begin
        cls    = classify(word);
        target = branch_target(pc, word);
    end
endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo
    import pfq_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  entry_t           din,
    input  logic             pop,
    output entry_t           dout,
    output logic             valid,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    entry_t           slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign do_push = push && !flush;
    assign do_pop  = pop && valid && !flush;
    assign valid   = (count != '0);
    assign dout    = slots[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
    import pfq_pkg::*;
#(
    parameter int                DEPTH      = 2,
    parameter int                EPOCH_W    = 3,
    parameter int                CNT_W      = $clog2(DEPTH + 1),
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   q_count,
    input  logic               rsp_valid,
    input  logic [EPOCH_W-1:0] rsp_tag,
    input  cls_e               rsp_cls,
    input  logic [ADDR_W-1:0]  rsp_target,
    input  logic               pred_taken,
    input  logic               redirect,
    input  logic [ADDR_W-1:0]  redirect_addr,
    output logic               req,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [EPOCH_W-1:0] req_tag,
    output logic [ADDR_W-1:0]  rsp_addr,
    output logic               accept,
    output logic               spec_cur
);
    logic [CNT_W-1:0]   outst;
    logic [EPOCH_W-1:0] epoch;
    logic [ADDR_W-1:0]  fetch_pc, resp_pc;
    logic               spec_q;
    logic               take;
    logic [CNT_W:0]     in_use;

    assign in_use   = {1'b0, outst} + {1'b0, q_count};
    assign req      = !rst && (in_use < (CNT_W + 1)'(DEPTH));
    assign req_addr = fetch_pc;
    assign req_tag  = epoch;
    assign rsp_addr = resp_pc;
    assign spec_cur = spec_q;
    assign accept   = rsp_valid && (rsp_tag == epoch) && !redirect;
    assign take     = accept && ((rsp_cls == CLS_JUMP) ||
                                 ((rsp_cls == CLS_COND) && pred_taken));

    always_ff @(posedge clk) begin
        if (rst) begin
            outst    <= '0;
            epoch    <= '0;
            fetch_pc <= RESET_ADDR;
            resp_pc  <= RESET_ADDR;
            spec_q   <= 1'b0;
        end else begin
            outst <= outst + CNT_W'(req) - CNT_W'(rsp_valid);
            if (redirect) begin
                fetch_pc <= redirect_addr;
                resp_pc  <= redirect_addr;
                epoch    <= epoch + EPOCH_W'(1);
                spec_q   <= 1'b0;
            end else begin
                if (take) begin
                    fetch_pc <= rsp_target;
                    resp_pc  <= rsp_target;
                    epoch    <= epoch + EPOCH_W'(1);
                end else begin
                    if (req)    fetch_pc <= next_seq(fetch_pc);
                    if (accept) resp_pc  <= next_seq(resp_pc);
                end
                if (accept && rsp_cls == CLS_COND) spec_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int                DEPTH      = 2,
    parameter int                EPOCH_W    = 3,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic               clk,
    input  logic               rst,
    output logic               imem_req,
    output logic [ADDR_W-1:0]  imem_addr,
    output logic [EPOCH_W-1:0] imem_tag,
    input  logic               imem_rvalid,
    input  logic [INSTR_W-1:0] imem_rdata,
    input  logic [EPOCH_W-1:0] imem_rtag,
    input  logic               pred_taken,
    input  logic               redirect,
    input  logic [ADDR_W-1:0]  redirect_addr,
    output logic               q_valid,
    output logic [INSTR_W-1:0] q_instr,
    output logic [ADDR_W-1:0]  q_addr,
    output logic               q_spec,
    input  logic               q_pop
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  q_count;
    logic              push, spec_cur;
    logic [ADDR_W-1:0] rsp_addr, rsp_target;
    cls_e              rsp_cls;
    entry_t            entry_in, entry_out;

    pfq_decode u_decode (
        .word   (imem_rdata),
        .pc     (rsp_addr),
        .cls    (rsp_cls),
        .target (rsp_target)
    );

    pfq_fetch_ctrl #(
        .DEPTH      (DEPTH),
        .EPOCH_W    (EPOCH_W),
        .CNT_W      (CNT_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .q_count       (q_count),
        .rsp_valid     (imem_rvalid),
        .rsp_tag       (imem_rtag),
        .rsp_cls       (rsp_cls),
        .rsp_target    (rsp_target),
        .pred_taken    (pred_taken),
        .redirect      (redirect),
        .redirect_addr (redirect_addr),
        .req           (imem_req),
        .req_addr      (imem_addr),
        .req_tag       (imem_tag),
        .rsp_addr      (rsp_addr),
        .accept        (push),
        .spec_cur      (spec_cur)
    );

    always_comb begin
        entry_in.instr = imem_rdata;
        entry_in.addr  = rsp_addr;
        entry_in.spec  = spec_cur;
    end

    pfq_fifo #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (redirect),
        .push  (push),
        .din   (entry_in),
        .pop   (q_pop),
        .dout  (entry_out),
        .valid (q_valid),
        .count (q_count)
    );

    assign q_instr = entry_out.instr;
    assign q_addr  = entry_out.addr;
    assign q_spec  = entry_out.spec;
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker
    import pfq_pkg::*;
#(
    parameter int DEPTH   = 2,
    parameter int EPOCH_W = 3,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               imem_req,
    input logic [ADDR_W-1:0]  imem_addr,
    input logic [EPOCH_W-1:0] imem_tag,
    input logic               imem_rvalid,
    input logic [EPOCH_W-1:0] imem_rtag,
    input logic               redirect,
    input logic [ADDR_W-1:0]  redirect_addr,
    input logic               q_valid,
    input logic               q_pop,
    input logic [ADDR_W-1:0]  q_addr,
    input logic [INSTR_W-1:0] q_instr,
    input logic [CNT_W-1:0]   q_count,
    input logic               push
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push && !(q_pop && q_valid) |-> q_count < CNT_W'(DEPTH)); // R3

    AST_NO_REQ_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        imem_req |-> q_count < CNT_W'(DEPTH)); // R3

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !q_valid); // R8

    AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (!imem_req || imem_addr == $past(redirect_addr))); // R7

    AST_EPOCH_BUMP: assert property (@(posedge clk) disable iff (rst)
        redirect |=> imem_tag != $past(imem_tag)); // R7

    AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        imem_rvalid && imem_rtag != imem_tag |-> !push); // R7

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        q_valid && !q_pop && !redirect |=> q_valid && $stable(q_addr) && $stable(q_instr)); // R9
endmodule

bind prefetch_queue pfq_checker #(
    .DEPTH   (DEPTH),
    .EPOCH_W (EPOCH_W),
    .CNT_W   (CNT_W)
) u_pfq_chk (
    .clk           (clk),
    .rst           (rst),
    .imem_req      (imem_req),
    .imem_addr     (imem_addr),
    .imem_tag      (imem_tag),
    .imem_rvalid   (imem_rvalid),
    .imem_rtag     (imem_rtag),
    .redirect      (redirect),
    .redirect_addr (redirect_addr),
    .q_valid       (q_valid),
    .q_pop         (q_pop),
    .q_addr        (q_addr),
    .q_instr       (q_instr),
    .q_count       (q_count),
    .push          (push)
);

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;
    import pfq_pkg::*;

    localparam int EPOCH_W = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               imem_req;
    logic [ADDR_W-1:0]  imem_addr;
    logic [EPOCH_W-1:0] imem_tag;
    logic               imem_rvalid;
    logic [INSTR_W-1:0] imem_rdata;
    logic [EPOCH_W-1:0] imem_rtag;
    logic               pred_taken = 1'b0;
    logic               redirect = 1'b0;
    logic [ADDR_W-1:0]  redirect_addr = '0;
    logic               q_valid;
    logic [INSTR_W-1:0] q_instr;
    logic [ADDR_W-1:0]  q_addr;
    logic               q_spec;
    logic               q_pop = 1'b0;

    always #10 clk = ~clk;

    prefetch_queue u_prefetch_queue (
        .clk           (clk),
        .rst           (rst),
        .imem_req      (imem_req),
        .imem_addr     (imem_addr),
        .imem_tag      (imem_tag),
        .imem_rvalid   (imem_rvalid),
        .imem_rdata    (imem_rdata),
        .imem_rtag     (imem_rtag),
        .pred_taken    (pred_taken),
        .redirect      (redirect),
        .redirect_addr (redirect_addr),
        .q_valid       (q_valid),
        .q_instr       (q_instr),
        .q_addr        (q_addr),
        .q_spec        (q_spec),
        .q_pop         (q_pop)
    );

    // Program image: jump at 0x05 (+10), conditional branch at 0x12 (-8).
    function automatic logic [INSTR_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        if (a == 16'h0005) return {2'b10, 18'h0, 12'd10};
        if (a == 16'h0012) return {2'b11, 18'h0, 12'hFF8};
        return {16'h0, a};
    endfunction

    // Two-cycle pipelined memory model.
    logic               m0v = 1'b0, m1v = 1'b0;
    logic [ADDR_W-1:0]  m0a, m1a;
    logic [EPOCH_W-1:0] m0t, m1t;
    always @(posedge clk) begin
        m0v <= imem_req;
        m0a <= imem_addr;
        m0t <= imem_tag;
        m1v <= m0v;
        m1a <= m0a;
        m1t <= m0t;
    end
    assign imem_rvalid = m1v;
    assign imem_rdata  = mem_word(m1a);
    assign imem_rtag   = m1t;

    typedef struct {
        logic [ADDR_W-1:0]  addr;
        logic [INSTR_W-1:0] word;
        logic               spec;
        string              tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Driver side of the scoreboard: walk the program and queue what must come out.
    task automatic add_path(input logic [ADDR_W-1:0] start, input int n,
                            input bit pred, input string first_tag);
        logic [ADDR_W-1:0]  a = start;
        logic [ADDR_W-1:0]  off;
        logic [INSTR_W-1:0] w;
        bit                 sp = 1'b0;
        string              t = first_tag;
        string              nt;
        for (int i = 0; i < n; i++) begin
            w = mem_word(a);
            exp_q.push_back('{a, w, sp, t});
            off = {{4{w[11]}}, w[11:0]};
            if (w[31:30] == 2'b10) begin
                a  = a + off;
                nt = "R4";
            end else if (w[31:30] == 2'b11) begin
                a  = pred ? a + off : a + 16'd1;
                sp = 1'b1;
                nt = "R5";
            end else begin
                a  = a + 16'd1;
                nt = sp ? "R6" : "R2";
            end
            t = nt;
        end
    endtask

    // Monitor: compare the head against the scoreboard and pop it.
    always @(negedge clk) begin
        exp_t e;
        if (!rst && !redirect && q_valid && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check(q_addr == e.addr, e.tag, "entry address", q_addr, e.addr);
            check(q_instr == e.word && q_spec == e.spec, e.tag, "entry word/spec",
                  {q_spec, q_instr}, {e.spec, e.word});
            q_pop = 1'b1;
        end else begin
            q_pop = 1'b0;
        end
    end

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (exp_q.size() > 0 && n < 2000) begin
            step();
            n++;
        end
        check(exp_q.size() == 0, tag, "scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic do_redirect(input logic [ADDR_W-1:0] a);
        redirect      = 1'b1;
        redirect_addr = a;
        step();
        redirect = 1'b0;
        check(q_valid == 1'b0, "R8", "empty after flush", q_valid, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] held;
        repeat (3) step();
        check(q_valid == 1'b0 && imem_req == 1'b0, "R1", "idle in reset",
              {q_valid, imem_req}, 0);
        rst = 1'b0;

        // Sequential run through the jump and a not-taken branch.
        add_path(16'h0000, 30, 1'b0, "R1");
        drain("R2");

        // No pops: queue fills, requests stop, head holds.
        repeat (5) step();
        held = q_addr;
        repeat (15) step();
        check(imem_req == 1'b0, "R3", "no request while full", imem_req, 0);
        check(q_valid == 1'b1, "R3", "queue holds entries", q_valid, 1);
        check(q_addr == held, "R9", "head stable", q_addr, held);

        // Flush while the queue is full.
        do_redirect(16'h0040);
        add_path(16'h0040, 20, 1'b0, "R7");
        drain("R7");

        // Predicted-taken loop over the conditional branch.
        pred_taken = 1'b1;
        do_redirect(16'h0008);
        add_path(16'h0008, 25, 1'b1, "R7");
        drain("R5");

        // Back-to-back redirects: nothing from the first address may appear.
        pred_taken    = 1'b0;
        redirect      = 1'b1;
        redirect_addr = 16'h0020;
        step();
        redirect_addr = 16'h0030;
        step();
        redirect = 1'b0;
        check(q_valid == 1'b0, "R8", "empty after second flush", q_valid, 0);
        add_path(16'h0030, 15, 1'b0, "R7");
        drain("R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule